// File: doc/BRIEF.md
# Cache Test Register Access Unit

This block gives software a test window into a 4-way set-associative cache of 128 sets with 16-byte lines. It owns the per-entry tag and data storage, the per-set valid bits and the per-set pseudo-LRU trees. Software reaches them only through three 32-bit test registers on a simple register port: a data register, a status register and a control register.

Writing the control register starts an operation chosen by its 2-bit code. The unit can load a line-wide fill buffer one word at a time, write the fill buffer plus a tag and valid bit into a chosen set and way, read a chosen entry into a line-wide read buffer and the status fields, or clear every valid bit one set per cycle. Only write-through behaviour is modelled. The normal lookup path and the bus side are outside the block.

Top module: `cache_test_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `busy` is low, and every valid bit and every LRU bit is zero.
- R2: Register addresses are 0 for data, 1 for status and 2 for control. Address 3 reads zero and ignores writes. A status write changes only the tag (bits 31..11) and the entry valid bit (bit 10); bits 9..0 ignore the write. The control register keeps bits 10..0 and reads zero above them.
- R3: The control fields are the index in bits 10..4, the way/word select in bits 3..2 and the code in bits 1..0. While the stored code is 00, a data register write also stores the value into fill-buffer word [3:2], and a data register read returns read-buffer word [3:2]. With any other code, a read returns the last value written to the data register.
- R4: A control write with code 01 stores the status tag, the status valid bit and the four fill-buffer words into the selected set and way.
- R5: A control write with code 10 loads the selected line into the read buffer. It also sets the status tag to the entry's tag, bit 10 to the entry's valid bit, bits 9..7 to the set's LRU bits, and bits 6..3 to the set's valid bits, with bit 3+w for way w.
- R6: On a code-01 write to way w, LRU bit 0 becomes 1 for w in {0,1} and 0 for w in {2,3}. Bit 1 becomes 1 for w=0 and 0 for w=1. Bit 2 becomes 1 for w=2 and 0 for w=3. Bits off the path of w keep their value, and a code-10 read leaves the LRU bits unchanged.
- R7: A control write with code 11 raises `busy` for exactly 128 cycles. After that every valid bit is zero, while the tags, data and LRU bits keep their values.
- R8: Every register write made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Read value of the addressed register (combinational) |
| busy | output | 1 | High while a flush is sweeping the sets |

## Verification
Every way of the first, second, middle and last sets is written in a different order per set. The resulting LRU trees therefore tell apart wrong path bits, a stuck root and a reversed pair choice. Tags, data words and valid patterns are built from set, way and word numbers, so a swapped index, way or word select returns a visibly wrong value. A flush is checked by counting busy cycles and by injecting register writes mid-sweep. Reads of sets that were never written, and status writes with the read-only bits set, show the fields that must not move.

// File: rtl/ctu_pkg.sv
// Package: shared geometry, operation codes and line type for the
// cache test register access unit. Assumes a power-of-two set count.
package ctu_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int WORDS  = 4;
    localparam int WORD_W = 32;
    localparam int TAG_W  = 21;
    localparam int SETS   = 128;
    localparam int LRU_W  = 3;

    typedef enum logic [1:0] {
        OP_BUF   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_FLUSH = 2'b11
    } test_op_e;
endpackage

// File: rtl/ctu_plru.sv
// Module: next-state logic of a 3-bit pseudo-LRU tree for one set.
// Bit 0 picks the way pair, bit 1 the way inside {0,1}, bit 2 the way
// inside {2,3}. An access makes the bits on its path point away from it.
// Assumes exactly four ways.
module ctu_plru (
    input  logic [2:0] cur,
    input  logic [1:0] way,
    output logic [2:0] nxt
);
    // Rewrite only the two tree bits on the accessed way's path.
    always_comb begin
        nxt    = cur;
        nxt[0] = ~way[1];
        if (way[1] == 1'b0) nxt[1] = ~way[0];
        else                nxt[2] = ~way[0];
    end
endmodule

// File: rtl/ctu_flush_seq.sv
// Module: flush sequencer. On start it walks every set index, one per
// cycle, asserting a clear strobe for that set, and holds busy high
// meanwhile. Assumes start is never raised while busy.
module ctu_flush_seq #(
    parameter int SETS = ctu_pkg::SETS,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

    logic [IDX_W-1:0] cnt_q;

    // Sweep counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == LAST) busy <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clr_en  = busy;
    assign clr_idx = cnt_q;

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> busy);
    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == LAST && !start) |=> !busy);
    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/ctu_store.sv
// Module: cache state storage. Holds per-entry tag and line data and
// per-set valid and pseudo-LRU bits. One write port updates an entry and
// its set's LRU tree; one combinational read port exposes an entry and
// its set; a clear port zeroes one set's valid bits. Assumes the write
// and clear ports are never active in the same cycle.
module ctu_store #(
    parameter int SETS   = ctu_pkg::SETS,
    parameter int WAYS   = ctu_pkg::WAYS,
    parameter int TAG_W  = ctu_pkg::TAG_W,
    parameter int LINE_W = ctu_pkg::WORDS * ctu_pkg::WORD_W,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_valid,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    output logic [WAYS-1:0]   rd_vset,
    output logic [2:0]        rd_lru,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [LINE_W-1:0] line_mem [SETS][WAYS];
    logic [WAYS-1:0]   valid_q  [SETS];
    logic [2:0]        lru_q    [SETS];
    logic [2:0]        lru_nxt;

    ctu_plru u_plru (
        .cur (lru_q[wr_idx]),
        .way (wr_way),
        .nxt (lru_nxt)
    );

    // Tag and line storage, written by a test write; never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx][wr_way]  <= wr_tag;
            line_mem[wr_idx][wr_way] <= wr_line;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // Per-set valid bits: reset, flush clear, or test write of one way.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[s] <= '0;
            else if (clr_en && clr_idx == IDX_W'(s))
                valid_q[s] <= '0;
            else if (wr_en && wr_idx == IDX_W'(s))
                valid_q[s][wr_way] <= wr_valid;
        end

        // Per-set LRU tree: reset or replacement update on test write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lru_q[s] <= '0;
            else if (wr_en && wr_idx == IDX_W'(s))
                lru_q[s] <= lru_nxt;
        end
    end

    // Combinational read port.
    always_comb begin
        rd_tag  = tag_mem[rd_idx][rd_way];
        rd_line = line_mem[rd_idx][rd_way];
        rd_vset = valid_q[rd_idx];
        rd_lru  = lru_q[rd_idx];
    end

    // R7
    clr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (valid_q[$past(clr_idx)] == '0));
    // R6
    lru_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lru_q[$past(wr_idx)][0] == !$past(wr_way[WAY_W-1])));
    // R4
    valid_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_en) |=> (valid_q[$past(wr_idx)][$past(wr_way)] == $past(wr_valid)));
    // R7
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));
endmodule

// File: rtl/cache_test_unit.sv
// Module: cache test register access unit (top). Decodes register writes
// into the data, status and control test registers, keeps the fill and
// read buffers, and launches write, read and flush operations on the
// storage. Assumes the register port is written at most once per cycle;
// reads are combinational on reg_addr.
module cache_test_unit #(
    parameter int SETS   = ctu_pkg::SETS,
    parameter int WORDS  = ctu_pkg::WORDS,
    parameter int WORD_W = ctu_pkg::WORD_W,
    parameter int TAG_W  = ctu_pkg::TAG_W,
    localparam int WAYS   = ctu_pkg::WAYS,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int LINE_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              busy
);
    import ctu_pkg::*;

    localparam int IDX_LSB = 4;
    localparam int SEL_LSB = 2;
    localparam int CTL_W   = IDX_LSB + IDX_W;

    logic [WORD_W-1:0] data_q;
    logic [TAG_W-1:0]  st_tag;
    logic              st_valid;
    logic [2:0]        st_lru;
    logic [WAYS-1:0]   st_vset;
    logic [IDX_W-1:0]  ctl_idx;
    logic [WAY_W-1:0]  ctl_sel;
    test_op_e          ctl_op;
    logic [WORD_W-1:0] fbuf [WORDS];
    logic [WORD_W-1:0] rbuf [WORDS];

    logic              live, wr_data, wr_stat, wr_ctl;
    logic [IDX_W-1:0]  new_idx;
    logic [WAY_W-1:0]  new_sel;
    test_op_e          new_op;
    logic              st_en, fl_start, rd_go;
    logic [LINE_W-1:0] fill_line, rd_line;
    logic [TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]   rd_vset;
    logic [2:0]        rd_lru;
    logic              clr_en;
    logic [IDX_W-1:0]  clr_idx;

    // Write decode: every write is dropped while the flush runs.
    always_comb begin
        live     = reg_we && !busy;
        wr_data  = live && reg_addr == 2'd0;
        wr_stat  = live && reg_addr == 2'd1;
        wr_ctl   = live && reg_addr == 2'd2;
        new_idx  = reg_wdata[IDX_LSB +: IDX_W];
        new_sel  = reg_wdata[SEL_LSB +: WAY_W];
        new_op   = test_op_e'(reg_wdata[1:0]);
        st_en    = wr_ctl && new_op == OP_WRITE;
        rd_go    = wr_ctl && new_op == OP_READ;
        fl_start = wr_ctl && new_op == OP_FLUSH;
    end

    // Pack the fill buffer into a line, word 0 in the low bits.
    for (genvar k = 0; k < WORDS; k++) begin : g_pack
        assign fill_line[k*WORD_W +: WORD_W] = fbuf[k];
    end

    ctu_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_en),
        .wr_idx   (new_idx),
        .wr_way   (new_sel),
        .wr_tag   (st_tag),
        .wr_valid (st_valid),
        .wr_line  (fill_line),
        .rd_idx   (new_idx),
        .rd_way   (new_sel),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line),
        .rd_vset  (rd_vset),
        .rd_lru   (rd_lru),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx)
    );

    ctu_flush_seq #(.SETS(SETS)) u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fl_start),
        .busy    (busy),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    // Data register.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= reg_wdata;
    end

    // Control register: index, way/word select and operation code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_idx <= '0;
            ctl_sel <= '0;
            ctl_op  <= OP_BUF;
        end else if (wr_ctl) begin
            ctl_idx <= new_idx;
            ctl_sel <= new_sel;
            ctl_op  <= new_op;
        end
    end

    // Status register: tag and valid from software or a test read; set fields from a test read only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_tag   <= '0;
            st_valid <= 1'b0;
            st_lru   <= '0;
            st_vset  <= '0;
        end else if (rd_go) begin
            st_tag   <= rd_tag;
            st_valid <= rd_vset[new_sel];
            st_lru   <= rd_lru;
            st_vset  <= rd_vset;
        end else if (wr_stat) begin
            st_tag   <= reg_wdata[WORD_W-1 -: TAG_W];
            st_valid <= reg_wdata[WORD_W-TAG_W-1];
        end
    end

    // Fill and read buffers, one word per slot.
    for (genvar k = 0; k < WORDS; k++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)
                fbuf[k] <= '0;
            else if (wr_data && ctl_op == OP_BUF && ctl_sel == WAY_W'(k))
                fbuf[k] <= reg_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)     rbuf[k] <= '0;
            else if (rd_go) rbuf[k] <= rd_line[k*WORD_W +: WORD_W];
        end
    end

    // Read mux over the three registers; address 3 reads zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            2'd0: reg_rdata = (ctl_op == OP_BUF) ? rbuf[ctl_sel] : data_q;
            2'd1: reg_rdata = {st_tag, st_valid, st_lru, st_vset, 3'b000};
            2'd2: reg_rdata = WORD_W'({ctl_idx, ctl_sel, ctl_op});
            default: reg_rdata = '0;
        endcase
    end

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we) |=> $stable({data_q, st_tag, st_valid, ctl_idx, ctl_sel, ctl_op}));
    // R2
    ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1 && !busy) |=> $stable({st_lru, st_vset}));
    // R2
    ctl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) |-> (reg_rdata[WORD_W-1:CTL_W] == '0));
endmodule

// File: tb/sim_cache_test_unit.sv
module sim_cache_test_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy;

    int nvec = 0;
    int nfail = 0;

    // Reference state, filled from the requirements.
    logic [20:0] tag_m   [128][4];
    logic [31:0] word_m  [128][4][4];
    logic        valid_m [128][4];
    logic [2:0]  lru_m   [128];
    logic [31:0] dq_m;

    cache_test_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input int s, input int w, input int op);
        return 32'((s << 4) | (w << 2) | op);
    endfunction

    // Tree after touching way w, taken straight from the R6 table.
    function automatic logic [2:0] lru_after(input logic [2:0] c, input int w);
        case (w)
            0: return {c[2], 1'b1, 1'b1};
            1: return {c[2], 1'b0, 1'b1};
            2: return {1'b1, c[1], 1'b0};
            default: return {1'b0, c[1], 1'b0};
        endcase
    endfunction

    function automatic logic [31:0] status_of(input int s, input int w);
        logic [3:0] vs;
        for (int k = 0; k < 4; k++) vs[k] = valid_m[s][k];
        return {tag_m[s][w], valid_m[s][w], lru_m[s], vs, 3'b000};
    endfunction

    int sets_list [4] = '{0, 1, 63, 127};

    initial begin
        logic [31:0] v, st_save;
        for (int s = 0; s < 128; s++) begin
            lru_m[s] = '0;
            for (int w = 0; w < 4; w++) valid_m[s][w] = 1'b0;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rreg(2'd0, v); check("R1 data", v, 32'h0);
        rreg(2'd1, v); check("R1 status", v, 32'h0);
        rreg(2'd2, v); check("R1 control", v, 32'h0);
        rreg(2'd3, v); check("R1 addr3", v, 32'h0);
        check("R1 busy", {31'b0, busy}, 32'h0);

        // R2: masks on status, control and address 3
        wreg(2'd1, 32'hFFFF_FFFF);
        rreg(2'd1, v); check("R2 status mask", v, 32'hFFFF_FC00);
        wreg(2'd2, 32'hFFFF_FFF0);
        rreg(2'd2, v); check("R2 control mask", v, 32'h0000_07F0);
        wreg(2'd3, 32'h1234_5678);
        rreg(2'd3, v); check("R2 addr3 ignored", v, 32'h0);

        // R4/R6: fill and write every way of four sets in set-dependent orders
        for (int i = 0; i < 4; i++) begin
            int s = sets_list[i];
            for (int j = 0; j < 4; j++) begin
                int w = (i % 2 == 1) ? 3 - ((j + i) % 4) : (j + i) % 4;
                for (int k = 0; k < 4; k++) begin
                    word_m[s][w][k] = 32'hC000_0000 ^ 32'(s << 16) ^ 32'(w << 8) ^ 32'(k) ^ 32'(s * 32'h0101_0101);
                    wreg(2'd2, ctl(s, k, 0));
                    wreg(2'd0, word_m[s][w][k]);
                    dq_m = word_m[s][w][k];
                end
                tag_m[s][w]   = {7'(s), 2'(w), 12'h5A3};
                valid_m[s][w] = !(s == 63 && w == 1);
                wreg(2'd1, {tag_m[s][w], valid_m[s][w], 10'h3FF});
                wreg(2'd2, ctl(s, w, 1));
                lru_m[s] = lru_after(lru_m[s], w);
            end
        end

        // R5/R3/R6: read back every entry, its status and its four words
        for (int i = 0; i < 4; i++) begin
            int s = sets_list[i];
            for (int w = 0; w < 4; w++) begin
                wreg(2'd2, ctl(s, w, 2));
                rreg(2'd1, v); check("R5 status after read", v, status_of(s, w));
                for (int k = 0; k < 4; k++) begin
                    wreg(2'd2, ctl(s, k, 0));
                    rreg(2'd0, v); check("R3 read buffer word", v, word_m[s][w][k]);
                end
            end
            // R6: reads left the tree as the writes set it
            wreg(2'd2, ctl(s, 0, 2));
            rreg(2'd1, v); check("R6 lru unchanged by reads", {29'b0, v[9:7]}, {29'b0, lru_m[s]});
        end

        // R5: a never-written set reports no valid bits and a zero tree
        wreg(2'd2, ctl(2, 3, 2));
        rreg(2'd1, v); check("R5 empty set", {21'b0, v[10:0]}, 32'h0);

        // R2: status write leaves bits 9..3 as the last read set them
        wreg(2'd2, ctl(1, 2, 2));
        wreg(2'd1, 32'h0000_03F8);
        rreg(2'd1, v);
        check("R2 read-only status bits", v, {21'h0, 1'b0, status_of(1, 2)[9:0]});
        wreg(2'd2, ctl(1, 2, 2));
        rreg(2'd1, st_save);

        // R7/R8: flush, with writes injected mid-sweep
        wreg(2'd2, ctl(0, 0, 3));
        begin
            int n = 0;
            while (busy && n < 1000) begin
                n++;
                if (n == 10) begin reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hFFFF_FFFF; end
                else if (n == 11) begin reg_addr = 2'd2; reg_wdata = ctl(5, 1, 2); end
                else if (n == 12) begin reg_addr = 2'd0; reg_wdata = 32'hDEAD_BEEF; end
                else if (n == 13) reg_we = 1'b0;
                @(negedge clk);
            end
            check("R7 busy length", 32'(n), 32'd128);
        end
        rreg(2'd1, v); check("R8 status kept during flush", v, st_save);
        rreg(2'd2, v); check("R8 control kept during flush", v, 32'h3);
        rreg(2'd0, v); check("R3 data register with code 11", v, dq_m);

        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 4; w++) valid_m[s][w] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            int s = sets_list[i];
            for (int w = 0; w < 4; w++) begin
                wreg(2'd2, ctl(s, w, 2));
                rreg(2'd1, v); check("R7 after flush", v, status_of(s, w));
            end
            wreg(2'd2, ctl(s, 3, 0));
            rreg(2'd0, v); check("R7 data kept by flush", v, word_m[s][3][3]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule